// File: doc/BRIEF.md
# Two-Wire Debug Link Master Frame Engine

This block is the host end of a two-wire serial debug link. The link has one clock line, which the master always drives, and one bidirectional data line. A client hands the engine a single command through a valid/acknowledge handshake. The command gives an instruction type, an 8-bit argument and up to four write bytes. The argument is the address for address frames, and its low bits are the byte-count code for data frames. The engine then produces the whole frame on the wire.

The engine generates each clock strobe from a programmable divider. It drives or releases the data line at the field boundaries that the instruction fixes. It polls the open-ended wait field, with a programmable limit on the number of strobes. It gathers any bits the target returns. When the frame has ended, it issues a one-cycle completion pulse that carries up to 32 bits of read data and a status code.

Top module: `twd_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, the clock line is high, the data driver enable is 0 and the completion pulse is low.
- R2: Each strobe holds the clock low for `div_i` system cycles and then high for `div_i` system cycles. A `div_i` value of 0 acts as 1. Strobes within a frame follow each other with no extra high cycles.
- R3: The data output and the data driver enable change only in a cycle where the clock line is low. They never change while the clock is high.
- R4: Every frame opens with one strobe with the driver disabled. Two driven instruction bits follow, least-significant bit first, using these codes: 00 data read, 01 data write, 10 address read, 11 address write.
- R5: An address write then drives the 8 argument bits, LSB first. An address read releases the line for 8 strobes and puts the bits sampled there into read data bits 7:0, LSB first. The upper read data bits are 0.
- R6: A data write drives the 2-bit length code from argument bits 1:0, LSB first. It then drives (code+1) bytes of the write data, starting at bit 0, LSB first, and then enters the wait field.
- R7: A data read drives the 2-bit length code, then enters the wait field. It then releases the line for (code+1)*8 strobes and stores the sampled bits in read data from bit 0 upward. The read data bits above those are 0.
- R8: In the wait field the line is released. The engine keeps strobing, sampling the data input at the end of each low phase, and leaves the field after the first strobe that samples a 1.
- R9: If max(`wait_max_i`,1) wait strobes in a row all sample 0, the frame is aborted and status reads 1. A data read then returns read data 0 and sends no data strobes. The stop strobe is still issued.
- R10: Every frame closes with one strobe with the driver disabled. When that strobe's high phase has ended, `done_o` pulses for exactly one cycle with `status_o` (0 success, 1 timeout) and `rdata_o`.
- R11: A command is taken only while the engine is idle and `req_valid_i` is 1, and `req_ack_o` then pulses for one cycle. While `req_valid_i` is 0, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Command present |
| req_ins_i | input | 2 | Instruction code |
| req_arg_i | input | 8 | Address, or length code in bits 1:0 |
| req_wdata_i | input | MAXB*8 | Write bytes, byte 0 in bits 7:0 |
| req_ack_o | output | 1 | One-cycle command accept pulse |
| div_i | input | DIVW | Strobe half-period in system cycles |
| wait_max_i | input | WMW | Maximum wait strobes |
| tck_o | output | 1 | Link clock line |
| tdo_o | output | 1 | Data line output value |
| tdo_oe_o | output | 1 | Data line driver enable |
| tdi_i | input | 1 | Data line input value |
| done_o | output | 1 | One-cycle frame completion pulse |
| rdata_o | output | MAXB*8 | Captured read data |
| status_o | output | 2 | 0 success, 1 wait timeout |

## Verification
The hardest situations to reach from the ports are the wait field running out, and the exact strobe at which a turnaround occurs. Both depend on what the target returns on individual strobes. The bench therefore contains a target model that counts clock strobes and puts a planned bit on the data input after each falling edge. For each command it holds 0 for a chosen number of wait strobes before giving 1, and it also provides read bits. It sweeps every instruction, every length code, several wait delays and several divider values. It also runs delays at and beyond the wait limit, including a limit of 0, so that both the last successful poll and the first timeout are exercised.

// File: rtl/twd_pkg.sv
package twd_pkg;

  typedef enum logic [1:0] {
    INS_DRD = 2'b00,
    INS_DWR = 2'b01,
    INS_ARD = 2'b10,
    INS_AWR = 2'b11
  } twd_ins_e;

  typedef enum logic [3:0] {
    FS_IDLE,
    FS_START,
    FS_INS,
    FS_ADDR,
    FS_LEN,
    FS_DATA,
    FS_WAIT,
    FS_STOP,
    FS_FIN
  } twd_fs_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1
  } twd_st_e;

endpackage

// File: rtl/twd_strobe_gen.sv
module twd_strobe_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tck_o,
  output logic            ready_o,
  output logic            smp_o
);

  logic            busy;
  logic            low;
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] eff;

  assign eff     = (div_i == '0) ? DIVW'(1) : div_i;
  // free now, or in the final cycle of a high phase
  assign ready_o = !busy || (!low && cnt == '0);
  // last low cycle: the clock rises on the next edge and tdi is sampled there
  assign smp_o   = busy && low && cnt == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      low   <= 1'b0;
      cnt   <= '0;
      tck_o <= 1'b1;
    end else if (go_i && ready_o) begin
      busy  <= 1'b1;
      low   <= 1'b1;
      tck_o <= 1'b0;
      cnt   <= eff - 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (low) begin
        low   <= 1'b0;
        tck_o <= 1'b1;
        cnt   <= eff - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/twd_wait_timer.sv
module twd_wait_timer #(
  parameter int WMW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [WMW-1:0] max_i,
  output logic           expire_o
);

  logic [WMW-1:0] cnt;
  logic [WMW-1:0] eff;
  logic [WMW:0]   nxt;

  assign eff      = (max_i == '0) ? WMW'(1) : max_i;
  assign nxt      = {1'b0, cnt} + 1'b1;
  assign expire_o = step_i && (nxt >= {1'b0, eff});

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
    end else if (step_i) begin
      cnt <= nxt[WMW-1:0];
    end
  end

endmodule

// File: rtl/twd_frame_ctrl.sv
module twd_frame_ctrl
  import twd_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int WMW  = 16,
  parameter int MAXB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [1:0]        req_ins_i,
  input  logic [7:0]        req_arg_i,
  input  logic [MAXB*8-1:0] req_wdata_i,
  input  logic [DIVW-1:0]   div_i,
  input  logic [WMW-1:0]    wait_max_i,
  output logic              req_ack_o,
  output logic [DIVW-1:0]   div_o,
  output logic [WMW-1:0]    wmax_o,
  input  logic              ready_i,
  input  logic              smp_i,
  output logic              go_o,
  output logic              wclr_o,
  output logic              wstep_o,
  input  logic              expire_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [MAXB*8-1:0] rdata_o,
  output logic [1:0]        status_o
);

  localparam int RDW  = MAXB * 8;
  localparam int IDXW = $clog2(RDW);
  localparam int LENW = (MAXB > 1) ? $clog2(MAXB) : 1;

  twd_fs_e          st;
  twd_ins_e         ins_q;
  logic [IDXW-1:0]  idx;
  logic [7:0]       arg_q;
  logic [RDW-1:0]   wd_q;
  logic [RDW-1:0]   rbuf;
  logic             tmo;
  logic [LENW-1:0]  len_q;
  logic [IDXW-1:0]  last_idx;
  logic             drv_oe;
  logic             drv_bit;

  assign len_q    = arg_q[LENW-1:0];
  assign last_idx = IDXW'((int'(len_q) + 1) * 8 - 1);
  assign go_o     = ready_i && (st != FS_IDLE) && (st != FS_FIN);
  assign wclr_o   = (st == FS_IDLE);
  assign wstep_o  = smp_i && (st == FS_WAIT) && !tdi_i;

  // value and enable for the strobe about to be issued
  always_comb begin
    drv_oe  = 1'b0;
    drv_bit = 1'b0;
    unique case (st)
      FS_INS: begin
        drv_oe  = 1'b1;
        drv_bit = ins_q[idx[0]];
      end
      FS_ADDR: begin
        drv_oe  = (ins_q == INS_AWR);
        drv_bit = arg_q[idx[2:0]];
      end
      FS_LEN: begin
        drv_oe  = 1'b1;
        drv_bit = len_q[idx[LENW-1:0]];
      end
      FS_DATA: begin
        drv_oe  = (ins_q == INS_DWR);
        drv_bit = wd_q[idx];
      end
      default: begin
        drv_oe  = 1'b0;
        drv_bit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      ins_q    <= INS_DRD;
      idx      <= '0;
      arg_q    <= '0;
      wd_q     <= '0;
      rbuf     <= '0;
      tmo      <= 1'b0;
      div_o    <= '0;
      wmax_o   <= '0;
      tdo_o    <= 1'b0;
      oe_o     <= 1'b0;
      req_ack_o <= 1'b0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
      status_o <= ST_OK;
    end else begin
      req_ack_o <= 1'b0;
      done_o    <= 1'b0;
      if (go_o) begin
        tdo_o <= drv_bit & drv_oe;
        oe_o  <= drv_oe;
      end
      unique case (st)
        FS_IDLE: begin
          if (req_valid_i) begin
            ins_q     <= twd_ins_e'(req_ins_i);
            arg_q     <= req_arg_i;
            wd_q      <= req_wdata_i;
            div_o     <= div_i;
            wmax_o    <= wait_max_i;
            rbuf      <= '0;
            tmo       <= 1'b0;
            idx       <= '0;
            req_ack_o <= 1'b1;
            st        <= FS_START;
          end
        end
        FS_FIN: begin
          if (ready_i) begin
            done_o   <= 1'b1;
            rdata_o  <= rbuf;
            status_o <= tmo ? ST_TIMEOUT : ST_OK;
            st       <= FS_IDLE;
          end
        end
        default: begin
          if (smp_i) begin
            unique case (st)
              FS_START: begin
                st  <= FS_INS;
                idx <= '0;
              end
              FS_INS: begin
                if (idx == IDXW'(1)) begin
                  idx <= '0;
                  st  <= ins_q[1] ? FS_ADDR : FS_LEN;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              FS_ADDR: begin
                if (ins_q == INS_ARD) rbuf[idx] <= tdi_i;
                if (idx == IDXW'(7)) begin
                  idx <= '0;
                  st  <= FS_STOP;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              FS_LEN: begin
                if (idx == IDXW'(LENW - 1)) begin
                  idx <= '0;
                  st  <= (ins_q == INS_DWR) ? FS_DATA : FS_WAIT;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              FS_DATA: begin
                if (ins_q == INS_DRD) rbuf[idx] <= tdi_i;
                if (idx == last_idx) begin
                  idx <= '0;
                  st  <= (ins_q == INS_DWR) ? FS_WAIT : FS_STOP;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              FS_WAIT: begin
                if (tdi_i) begin
                  idx <= '0;
                  st  <= (ins_q == INS_DWR) ? FS_STOP : FS_DATA;
                end else if (expire_i) begin
                  tmo <= 1'b1;
                  st  <= FS_STOP;
                end
              end
              FS_STOP: st <= FS_FIN;
              default: st <= FS_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/twd_master.sv
module twd_master #(
  parameter int DIVW = 8,
  parameter int WMW  = 16,
  parameter int MAXB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [1:0]        req_ins_i,
  input  logic [7:0]        req_arg_i,
  input  logic [MAXB*8-1:0] req_wdata_i,
  output logic              req_ack_o,
  input  logic [DIVW-1:0]   div_i,
  input  logic [WMW-1:0]    wait_max_i,
  output logic              tck_o,
  output logic              tdo_o,
  output logic              tdo_oe_o,
  input  logic              tdi_i,
  output logic              done_o,
  output logic [MAXB*8-1:0] rdata_o,
  output logic [1:0]        status_o
);

  logic [DIVW-1:0] div_q;
  logic [WMW-1:0]  wmax_q;
  logic            s_ready;
  logic            s_smp;
  logic            s_go;
  logic            w_clr;
  logic            w_step;
  logic            w_exp;

  twd_strobe_gen #(.DIVW(DIVW)) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .go_i    (s_go),
    .div_i   (div_q),
    .tck_o   (tck_o),
    .ready_o (s_ready),
    .smp_o   (s_smp)
  );

  twd_wait_timer #(.WMW(WMW)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (w_clr),
    .step_i   (w_step),
    .max_i    (wmax_q),
    .expire_o (w_exp)
  );

  twd_frame_ctrl #(.DIVW(DIVW), .WMW(WMW), .MAXB(MAXB)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_ins_i   (req_ins_i),
    .req_arg_i   (req_arg_i),
    .req_wdata_i (req_wdata_i),
    .div_i       (div_i),
    .wait_max_i  (wait_max_i),
    .req_ack_o   (req_ack_o),
    .div_o       (div_q),
    .wmax_o      (wmax_q),
    .ready_i     (s_ready),
    .smp_i       (s_smp),
    .go_o        (s_go),
    .wclr_o      (w_clr),
    .wstep_o     (w_step),
    .expire_i    (w_exp),
    .tdi_i       (tdi_i),
    .tdo_o       (tdo_o),
    .oe_o        (tdo_oe_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .status_o    (status_o)
  );

endmodule

// File: rtl/twd_master_chk.sv
module twd_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       tck,
  input logic       tdo,
  input logic       oe,
  input logic       done,
  input logic       ack,
  input logic [1:0] status
);

  // R3
  pins_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tdo) && $stable(oe)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  done_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (tck && !oe));

  // R10
  status_legal_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (status <= 2'd1));

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R11
  ack_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!done && tck && !oe));

endmodule

bind twd_master twd_master_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tck    (tck_o),
  .tdo    (tdo_o),
  .oe     (tdo_oe_o),
  .done   (done_o),
  .ack    (req_ack_o),
  .status (status_o)
);

// File: tb/twd_master_bench.sv
`timescale 1ns/1ps
module twd_master_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_ins = 2'b00;
  logic [7:0]  req_arg = 8'h00;
  logic [31:0] req_wdata = 32'h0;
  logic        req_ack;
  logic [7:0]  div = 8'd1;
  logic [15:0] wmax = 16'd4;
  logic        tck, tdo, oe;
  logic        tdi = 1'b0;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  status;

  int total = 0;
  int bad = 0;

  bit exp_oe [0:127];
  bit exp_do [0:127];
  bit plan_di[0:127];
  bit got_oe [0:127];
  bit got_do [0:127];
  int n_exp;
  int sidx = 0;
  logic [31:0] exp_rd;
  int exp_st;
  int effdiv = 1;
  bit track = 0;
  int lowc = 0;
  int highc = 0;
  int werr = 0;

  always #2.5 clk = ~clk;

  twd_master u_twd_master (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ins_i(req_ins),
    .req_arg_i(req_arg), .req_wdata_i(req_wdata), .req_ack_o(req_ack),
    .div_i(div), .wait_max_i(wmax), .tck_o(tck), .tdo_o(tdo),
    .tdo_oe_o(oe), .tdi_i(tdi), .done_o(done), .rdata_o(rdata),
    .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // target model: present the planned bit after each falling clock edge
  always @(negedge tck) begin
    if (track && sidx > 0 && highc != effdiv) werr++;
    highc = 0;
    tdi = (sidx < 128) ? plan_di[sidx] : 1'b0;
  end

  always @(posedge tck) begin
    if (track && lowc != effdiv) werr++;
    lowc = 0;
    highc = 0;
    if (sidx < 128) begin
      got_oe[sidx] = oe;
      got_do[sidx] = tdo;
    end
    sidx++;
  end

  always @(negedge clk) begin
    if (track) begin
      if (!tck) lowc++;
      else highc++;
    end
  end

  task automatic add(input bit o, input bit d, input bit di);
    exp_oe[n_exp]  = o;
    exp_do[n_exp]  = d;
    plan_di[n_exp] = di;
    n_exp++;
  endtask

  task automatic wait_field(input int nz, input int wm, output bit tmo);
    int effm;
    int k;
    effm = (wm == 0) ? 1 : wm;
    tmo = (nz >= effm);
    k = tmo ? effm : nz + 1;
    for (int j = 0; j < k; j++) add(1'b0, 1'b0, (!tmo && j == nz));
  endtask

  task automatic build(input logic [1:0] ins, input logic [7:0] arg,
                       input logic [31:0] wd, input int nz,
                       input logic [31:0] rp, input int wm);
    int nb;
    bit tmo;
    for (int j = 0; j < 128; j++) begin
      exp_oe[j] = 0; exp_do[j] = 0; plan_di[j] = 0;
    end
    n_exp = 0;
    exp_rd = 32'h0;
    exp_st = 0;
    add(0, 0, 0);
    add(1, ins[0], 0);
    add(1, ins[1], 0);
    nb = int'(arg[1:0]) + 1;
    case (ins)
      2'b11: for (int j = 0; j < 8; j++) add(1, arg[j], 0);
      2'b10: begin
        for (int j = 0; j < 8; j++) add(0, 0, rp[j]);
        exp_rd[7:0] = rp[7:0];
      end
      2'b01: begin
        add(1, arg[0], 0);
        add(1, arg[1], 0);
        for (int j = 0; j < nb * 8; j++) add(1, wd[j], 0);
        wait_field(nz, wm, tmo);
        exp_st = tmo ? 1 : 0;
      end
      default: begin
        add(1, arg[0], 0);
        add(1, arg[1], 0);
        wait_field(nz, wm, tmo);
        exp_st = tmo ? 1 : 0;
        if (!tmo) begin
          for (int j = 0; j < nb * 8; j++) begin
            add(0, 0, rp[j]);
            exp_rd[j] = rp[j];
          end
        end
      end
    endcase
    add(0, 0, 0);
  endtask

  task automatic run(input logic [1:0] ins, input logic [7:0] arg,
                     input logic [31:0] wd, input int nz,
                     input logic [31:0] rp, input int wm, input int dv,
                     input string tag);
    int guard;
    int mism;
    build(ins, arg, wd, nz, rp, wm);
    @(negedge clk);
    div = 8'(dv);
    wmax = 16'(wm);
    effdiv = (dv == 0) ? 1 : dv;
    sidx = 0; lowc = 0; highc = 0; werr = 0;
    req_ins = ins; req_arg = arg; req_wdata = wd;
    req_valid = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_ack && guard < 50);
    chk(req_ack, "R11 accept", req_ack, 1);
    req_valid = 1'b0;
    track = 1;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    track = 0;
    chk(done, {tag, " R10 done"}, done, 1);
    chk(sidx == n_exp, {tag, " strobe count"}, sidx, n_exp);
    mism = 0;
    for (int j = 0; j < n_exp; j++)
      if (got_oe[j] != exp_oe[j] || (exp_oe[j] && got_do[j] != exp_do[j])) mism++;
    chk(mism == 0, {tag, " wire bits"}, mism, 0);
    chk(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    chk(int'(status) == exp_st, {tag, " R10 status"}, status, exp_st);
    chk(werr == 0, "R2 strobe widths", werr, 0);
    chk(tck && !oe, "R1 line idle at done", {tck, oe}, 2'b10);
    @(negedge clk);
    chk(!done, "R10 done single", done, 0);
    tdi = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tck && !oe && !done && !req_ack, "R1 reset state", {tck, oe, done, req_ack}, 4'b1000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(tck && !oe && !done, "R1 after reset", {tck, oe, done}, 3'b100);
    // R11: no request, no strobe
    sidx = 0;
    repeat (20) @(negedge clk);
    chk(sidx == 0 && !req_ack && tck, "R11 idle without request", sidx, 0);

    for (int dv = 1; dv <= 3; dv++) begin
      run(2'b11, 8'hA5 ^ 8'(dv * 19), 32'h0, 0, 32'h0, 4, dv, "R4 R5 addr write");
      run(2'b10, 8'h00, 32'h0, 0, 32'h0000_00C3 ^ 32'(dv * 37), 4, dv, "R4 R5 addr read");
      for (int ln = 0; ln < 4; ln++) begin
        for (int nz = 0; nz < 3; nz++) begin
          run(2'b01, 8'(ln) | 8'hF0, 32'hC3A5_0F96 ^ 32'(ln * 4099 + dv * 77 + nz),
              nz, 32'h0, 4, dv, "R6 R8 data write");
          run(2'b00, 8'(ln) | 8'h5C, 32'h0, nz,
              32'h9E37_79B9 ^ 32'(ln * 131 + dv * 7 + nz * 65537), 4, dv, "R7 R8 data read");
        end
      end
    end
    // R2: divider value 0 behaves as 1
    run(2'b11, 8'h3C, 32'h0, 0, 32'h0, 4, 0, "R2 R5 div zero");
    // R8: last successful poll at the limit
    run(2'b00, 8'h03, 32'h0, 2, 32'hDEAD_BEEF, 3, 2, "R8 read poll at limit");
    // R9: timeouts
    run(2'b01, 8'h01, 32'h0000_BEEF, 5, 32'h0, 3, 2, "R9 write timeout");
    run(2'b00, 8'h02, 32'h0, 9, 32'hFFFF_FFFF, 3, 1, "R9 read timeout");
    run(2'b00, 8'h00, 32'h0, 0, 32'h0000_0081, 0, 1, "R8 zero limit ok");
    run(2'b00, 8'h00, 32'h0, 1, 32'h0000_0081, 0, 3, "R9 zero limit timeout");
    run(2'b01, 8'h00, 32'h0000_005A, 1, 32'h0, 0, 1, "R9 write zero limit");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule